// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steps through a stored microprogram and turns each 36-bit instruction into the control signals for a set of functional units and a data memory. It keeps its own program memory. The program is loaded through a simple write port while the sequencer is idle. A pulse on `go_i` runs the program from address 0 until an end instruction is reached.

Every transfer between the data memory and a unit lasts a fixed number of word beats. That number is the full operand width divided by the word width: 4, 2 or 1 beats for 34-, 68- or 136-bit words. During a transfer the memory address advances by one on each beat. Which instruction comes next depends only on the opcode and the immediate field, and never on any data, so every run of a program has the same timing.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is held, and after it is released with no go pulse, `busy_o`, `done_o`, every strobe, address, selector and beat output, and `pc_o` are all 0.
- R2: Instruction fields are packed as: opcode bits 35:32, unit index 31:29, mode 28:27, address A 26:18, address B 17:9, immediate 8:0. Opcode values are 0 nop, 1 read, 2 write, 3 wait, 4 jump and 5 end.
- R3: When `go_i` is sampled high while idle, `done_o` clears. Execution starts at address 0, and the first instruction drives the outputs in the cycle after that edge. When `go_i` is high while busy, it has no effect.
- R4: A read lasts S = FULL_W/WORD_W cycles. On beat j it asserts `mem_re_o` and `unit_load_o`, drives `mem_raddr_a_o` = A+j, `mem_raddr_b_o` = B+j and `beat_o` = j, and presents the unit index and mode. `unit_start_o` is high on beat 0 only.
- R5: A write lasts S cycles. On beat j it asserts `mem_we_o` and `unit_take_o`, drives `mem_waddr_o` = A+j and `beat_o` = j, and presents the unit index and mode.
- R6: A wait lasts max(imm,1) cycles. During a wait no strobe is raised and all addresses, selectors and beat outputs are 0.
- R7: A nop, and any opcode from 6 to 15, lasts exactly one cycle with no strobe, whatever its other fields hold.
- R8: A jump lasts one cycle, raises no strobe, and the next instruction is fetched from the immediate address.
- R9: An end lasts one cycle. After it, `busy_o` is 0 and `done_o` is 1, and `done_o` holds until the next accepted go.
- R10: Without a jump, the next instruction address is the current one plus 1, wrapping from 511 to 0. Beat addresses A+j and B+j also wrap modulo 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start a run from address 0 (used only when idle) |
| prog_we_i | input | 1 | Program memory write enable |
| prog_waddr_i | input | 9 | Program memory write address |
| prog_wdata_i | input | 36 | Instruction word to store |
| busy_o | output | 1 | A program is running |
| done_o | output | 1 | Last run finished on an end instruction |
| pc_o | output | 9 | Address of the executing instruction |
| unit_sel_o | output | 3 | Target unit index during a transfer |
| unit_mode_o | output | 2 | Operation mode during a transfer |
| unit_start_o | output | 1 | Start pulse on the first beat of a read |
| unit_load_o | output | 1 | Operand beat is being delivered to the unit |
| unit_take_o | output | 1 | Result beat is being taken from the unit |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_raddr_a_o | output | 9 | First operand read address |
| mem_raddr_b_o | output | 9 | Second operand read address |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_waddr_o | output | 9 | Data memory write address |
| beat_o | output | 2 | Beat index inside a transfer |

## Verification
Wrap-around at the top of both address spaces is hard to reach from the ports. One way is for the program counter to run off address 511. The other is for a multi-beat transfer whose base sits near 511 to carry its beat addresses past 0. The stimulus jumps straight to address 510, and places reads and writes with bases at 509 and 510, so that both wraps happen within a few cycles. Go pulses that land in the middle of a transfer are also hard to time. The bench raises one on a chosen cycle of a run and compares the whole run, cycle by cycle, against a model that ignores it.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int INSTR_W = 36;
  localparam int OP_W    = 4;
  localparam int UNIT_W  = 3;
  localparam int MODE_W  = 2;
  localparam int ADDR_W  = 9;
  localparam int IMM_W   = 9;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_READ  = 4'd1,
    OP_WRITE = 4'd2,
    OP_WAIT  = 4'd3,
    OP_JUMP  = 4'd4,
    OP_END   = 4'd5
  } opcode_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [UNIT_W-1:0] unit;
    logic [MODE_W-1:0] mode;
    logic [ADDR_W-1:0] addr_a;
    logic [ADDR_W-1:0] addr_b;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic wt;
    logic jmp;
    logic fin;
  } dec_t;
endpackage

// File: rtl/ucseq_prog_ram.sv
module ucseq_prog_ram #(
  parameter int W  = 36,
  parameter int AW = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ucseq_decode.sv
module ucseq_decode
  import ucseq_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o = '0;
    case (op_i)
      OP_READ:  dec_o.rd  = 1'b1;
      OP_WRITE: dec_o.wr  = 1'b1;
      OP_WAIT:  dec_o.wt  = 1'b1;
      OP_JUMP:  dec_o.jmp = 1'b1;
      OP_END:   dec_o.fin = 1'b1;
      default:  dec_o = '0; // nop and unused codes
    endcase
  end
endmodule

// File: rtl/ucseq_loop_ctr.sv
module ucseq_loop_ctr #(
  parameter int CNT_W = 9,
  parameter int BEATS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             xfer_i,
  input  logic             wait_i,
  input  logic [CNT_W-1:0] imm_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  always_comb begin
    if (xfer_i)      last_o = (cnt_o == LAST_BEAT);
    else if (wait_i) last_o = (imm_i == '0) || (cnt_o == imm_i - 1'b1);
    else             last_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (!run_i || last_o)  cnt_o <= '0;
    else                        cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucseq_pkg::*;
#(
  parameter int FULL_W = 136,
  parameter int WORD_W = 34,
  localparam int BEATS  = FULL_W / WORD_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic                 prog_we_i,
  input  logic [ADDR_W-1:0]    prog_waddr_i,
  input  logic [INSTR_W-1:0]   prog_wdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [UNIT_W-1:0]    unit_sel_o,
  output logic [MODE_W-1:0]    unit_mode_o,
  output logic                 unit_start_o,
  output logic                 unit_load_o,
  output logic                 unit_take_o,
  output logic                 mem_re_o,
  output logic [ADDR_W-1:0]    mem_raddr_a_o,
  output logic [ADDR_W-1:0]    mem_raddr_b_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_waddr_o,
  output logic [BEAT_W-1:0]    beat_o
);
  localparam int PC_W  = ADDR_W;
  localparam int CNT_W = IMM_W;

  logic                 running_q, done_q;
  logic [PC_W-1:0]      pc_q, pc_nxt, fetch_addr;
  logic [INSTR_W-1:0]   ir_raw;
  instr_t               ir;
  dec_t                 dec;
  logic [CNT_W-1:0]     cnt;
  logic [ADDR_W-1:0]    ofs;
  logic                 last, xfer, advance, rd_act, wr_act;

  ucseq_prog_ram #(.W(INSTR_W), .AW(PC_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (prog_we_i),
    .waddr_i (prog_waddr_i),
    .wdata_i (prog_wdata_i),
    .raddr_i (fetch_addr),
    .rdata_o (ir_raw)
  );

  assign ir = instr_t'(ir_raw);

  ucseq_decode u_dec (
    .op_i  (ir.op),
    .dec_o (dec)
  );

  assign xfer = dec.rd | dec.wr;

  ucseq_loop_ctr #(.CNT_W(CNT_W), .BEATS(BEATS)) u_loop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (running_q),
    .xfer_i (xfer),
    .wait_i (dec.wt),
    .imm_i  (ir.imm),
    .cnt_o  (cnt),
    .last_o (last)
  );

  assign advance = running_q & last;
  assign pc_nxt  = dec.jmp ? ir.imm : pc_q + 1'b1;

  // Prefetch: the next instruction's word is ready when the current one retires
  always_comb begin
    if (!running_q)   fetch_addr = '0;
    else if (advance) fetch_addr = pc_nxt;
    else              fetch_addr = pc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      pc_q      <= '0;
    end else if (!running_q) begin
      if (go_i) begin
        running_q <= 1'b1;
        done_q    <= 1'b0;
        pc_q      <= '0;
      end
    end else if (advance) begin
      if (dec.fin) begin
        running_q <= 1'b0;
        done_q    <= 1'b1;
      end else begin
        pc_q <= pc_nxt;
      end
    end
  end

  assign ofs    = ADDR_W'(cnt);
  assign rd_act = running_q & dec.rd;
  assign wr_act = running_q & dec.wr;

  assign unit_sel_o    = (rd_act | wr_act) ? ir.unit : '0;
  assign unit_mode_o   = (rd_act | wr_act) ? ir.mode : '0;
  assign unit_start_o  = rd_act & (cnt == '0);
  assign unit_load_o   = rd_act;
  assign unit_take_o   = wr_act;
  assign mem_re_o      = rd_act;
  assign mem_raddr_a_o = rd_act ? ir.addr_a + ofs : '0;
  assign mem_raddr_b_o = rd_act ? ir.addr_b + ofs : '0;
  assign mem_we_o      = wr_act;
  assign mem_waddr_o   = wr_act ? ir.addr_a + ofs : '0;
  assign beat_o        = (rd_act | wr_act) ? cnt[BEAT_W-1:0] : '0;
  assign pc_o          = pc_q;
  assign busy_o        = running_q;
  assign done_o        = done_q;
endmodule

module ucode_sequencer_chk #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              go_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic              unit_start_o,
  input logic [BEAT_W-1:0] beat_o,
  input logic [8:0]        mem_raddr_a_o,
  input logic [8:0]        pc_o
);
  localparam logic [BEAT_W-1:0] LASTB = BEAT_W'(BEATS - 1);

  assert_rd_wr_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_start_beat0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_start_o |-> (mem_re_o && beat_o == '0));

  assert_beat_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && beat_o != LASTB) |=>
      (mem_re_o && beat_o == $past(beat_o) + 1'b1 &&
       mem_raddr_a_o == $past(mem_raddr_a_o) + 1'b1));

  assert_pc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && beat_o != LASTB) |=> $stable(pc_o));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !mem_we_o && !unit_start_o));

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_stop_sets_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_go_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && go_i) |=> (busy_o || done_o));
endmodule

bind ucode_sequencer ucode_sequencer_chk #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .go_i          (go_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .mem_re_o      (mem_re_o),
  .mem_we_o      (mem_we_o),
  .unit_start_o  (unit_start_o),
  .beat_o        (beat_o),
  .mem_raddr_a_o (mem_raddr_a_o),
  .pc_o          (pc_o)
);

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;
  localparam int FULL_W = 136;
  localparam int WORD_W = 34;
  localparam int BEATS  = FULL_W / WORD_W;

  logic        clk = 1'b0;
  logic        rst_ni, go_i, prog_we_i;
  logic [8:0]  prog_waddr_i;
  logic [35:0] prog_wdata_i;
  logic        busy_o, done_o, unit_start_o, unit_load_o, unit_take_o;
  logic        mem_re_o, mem_we_o;
  logic [8:0]  pc_o, mem_raddr_a_o, mem_raddr_b_o, mem_waddr_o;
  logic [2:0]  unit_sel_o;
  logic [1:0]  unit_mode_o, beat_o;

  always #5 clk = ~clk;

  ucode_sequencer #(.FULL_W(FULL_W), .WORD_W(WORD_W)) u_ucode_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .go_i(go_i),
    .prog_we_i(prog_we_i), .prog_waddr_i(prog_waddr_i), .prog_wdata_i(prog_wdata_i),
    .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o),
    .unit_sel_o(unit_sel_o), .unit_mode_o(unit_mode_o),
    .unit_start_o(unit_start_o), .unit_load_o(unit_load_o), .unit_take_o(unit_take_o),
    .mem_re_o(mem_re_o), .mem_raddr_a_o(mem_raddr_a_o), .mem_raddr_b_o(mem_raddr_b_o),
    .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o), .beat_o(beat_o)
  );

  logic [35:0] prog [512];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [8:0] m_pc;
  int   m_cnt;
  bit   m_run, m_done;

  function automatic logic [35:0] mk(int op, int unit, int mode, int a, int b, int imm);
    return {4'(op), 3'(unit), 2'(mode), 9'(a), 9'(b), 9'(imm)};
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R8";
      4'd5: return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [49:0] act_vec();
    return {busy_o, done_o, pc_o, unit_sel_o, unit_mode_o, unit_start_o, unit_load_o,
            unit_take_o, mem_re_o, mem_raddr_a_o, mem_raddr_b_o, mem_we_o, mem_waddr_o, beat_o};
  endfunction

  function automatic logic [49:0] exp_vec();
    logic [35:0] ins = prog[m_pc];
    logic rd = (ins[35:32] == 4'd1);
    logic wr = (ins[35:32] == 4'd2);
    logic x  = rd | wr;
    logic [8:0] ofs = 9'(m_cnt);
    if (!m_run) return {1'b0, m_done, m_pc, 39'b0};
    return {1'b1, 1'b0, m_pc,
            x ? ins[31:29] : 3'd0, x ? ins[28:27] : 2'd0,
            rd && (m_cnt == 0), rd, wr, rd,
            rd ? 9'(ins[26:18] + ofs) : 9'd0,
            rd ? 9'(ins[17:9] + ofs) : 9'd0,
            wr, wr ? 9'(ins[26:18] + ofs) : 9'd0,
            x ? 2'(m_cnt) : 2'd0};
  endfunction

  task automatic step_model();
    logic [35:0] ins = prog[m_pc];
    int op = int'(ins[35:32]);
    int imm = int'(ins[8:0]);
    bit last;
    if (op == 1 || op == 2) last = (m_cnt == BEATS - 1);
    else if (op == 3)       last = (imm == 0) || (m_cnt == imm - 1);
    else                    last = 1'b1;
    if (last) begin
      m_cnt = 0;
      if (op == 5) begin m_run = 1'b0; m_done = 1'b1; end
      else if (op == 4) m_pc = 9'(imm);
      else m_pc = m_pc + 9'd1;
    end else m_cnt++;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input int addr, input logic [35:0] w);
    @(negedge clk);
    prog_we_i = 1'b1; prog_waddr_i = 9'(addr); prog_wdata_i = w;
    prog[addr] = w;
    @(negedge clk);
    prog_we_i = 1'b0;
  endtask

  task automatic run_prog(input int max_cyc, input int go_at, input string ovr, output int ncyc);
    string tag;
    m_pc = '0; m_cnt = 0; m_run = 1'b1; m_done = 1'b0; ncyc = 0;
    @(negedge clk); go_i = 1'b1;
    @(negedge clk); go_i = 1'b0;
    while (m_run && ncyc < max_cyc) begin
      if (ncyc == 0 || ncyc == go_at) tag = "R3";
      else if (ovr != "") tag = ovr;
      else tag = req_of(prog[m_pc][35:32]);
      chk(act_vec() == exp_vec(), tag, 64'(act_vec()), 64'(exp_vec()));
      go_i = (ncyc == go_at);
      step_model();
      ncyc++;
      @(negedge clk);
    end
    go_i = 1'b0;
    if (!m_run) chk(act_vec() == exp_vec(), "R9", 64'(act_vec()), 64'(exp_vec()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R9 act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    rst_ni = 1'b0; go_i = 1'b0; prog_we_i = 1'b0; prog_waddr_i = '0; prog_wdata_i = '0;
    m_pc = '0; m_cnt = 0; m_run = 1'b0; m_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(act_vec() == exp_vec(), "R1", 64'(act_vec()), 64'(exp_vec()));
    rst_ni = 1'b1;
    @(negedge clk);
    chk(act_vec() == exp_vec(), "R1", 64'(act_vec()), 64'(exp_vec()));
    for (int a = 0; a < 512; a++) load(a, '0);

    // mixed program: every opcode, address wrap inside transfers
    load(0, mk(1, 1, 2, 10, 20, 0));
    load(1, mk(2, 3, 1, 510, 7, 0));
    load(2, mk(1, 5, 3, 509, 511, 0));
    load(3, mk(3, 7, 3, 55, 66, 0));
    load(4, mk(3, 0, 0, 0, 0, 1));
    load(5, mk(3, 2, 1, 3, 4, 5));
    for (int k = 0; k < 10; k++) load(6 + k, mk(6 + k, 7, 3, 100, 200, 300));
    load(16, mk(0, 6, 2, 33, 44, 55));
    load(17, mk(4, 0, 0, 0, 0, 40));
    load(18, mk(5, 0, 0, 0, 0, 0));
    load(40, mk(1, 2, 1, 300, 301, 0));
    load(41, mk(4, 1, 1, 1, 1, 45));
    load(45, mk(5, 0, 0, 0, 0, 0));
    run_prog(200, 3, "", n);
    chk(n == 37, "R8", 64'(n), 64'd37);
    // restart after done, go held during a wait
    run_prog(200, 15, "", n);
    chk(n == 37, "R9", 64'(n), 64'd37);

    // wait duration sweep
    for (int imm = 0; imm <= 40; imm++) begin
      load(0, mk(3, imm % 8, imm % 4, imm, 511 - imm, imm));
      load(1, mk(5, 0, 0, 0, 0, 0));
      run_prog(100, -1, "", n);
      chk(n == ((imm == 0) ? 1 : imm) + 1, "R6", 64'(n), 64'(((imm == 0) ? 1 : imm) + 1));
    end

    // field position / address sweep over read and write
    for (int base = 0; base < 512; base += 29) begin
      load(0, mk(1, base % 8, base % 4, base, 511 - base, base));
      load(1, mk(2, (base + 3) % 8, (base + 1) % 4, base + 3, base, 511 - base));
      load(2, mk(5, 0, 0, 0, 0, 0));
      run_prog(100, 2, "R2", n);
      chk(n == 2 * BEATS + 1, "R5", 64'(n), 64'(2 * BEATS + 1));
    end

    // program counter wrap, then reset in the middle of a run
    load(0, mk(4, 0, 0, 0, 0, 510));
    load(510, mk(1, 4, 2, 1, 2, 0));
    load(511, mk(0, 0, 0, 0, 0, 0));
    run_prog(30, -1, "R10", n);
    chk(busy_o == 1'b1, "R10", 64'(busy_o), 64'd1);
    rst_ni = 1'b0;
    m_run = 1'b0; m_pc = '0; m_done = 1'b0; m_cnt = 0;
    #1;
    chk(act_vec() == exp_vec(), "R1", 64'(act_vec()), 64'(exp_vec()));
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(act_vec() == exp_vec(), "R1", 64'(act_vec()), 64'(exp_vec()));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule